// File: doc/BRIEF.md
# SPI Command Frame Builder

This host-side block turns one command request into the byte sequence of a command frame for a byte-wide SPI shifter. A request carries an opcode, a 24-bit address, a 32-bit word (a write value or a transfer length, depending on the opcode), a clockless flag and a checksum-enable flag. The block works out the frame layout for the opcode, captures it, and issues the bytes most significant first over a valid/ready byte stream. When the checksum is enabled, a CRC7 byte computed over everything already sent is issued as the final byte.

The controller raises `start` for one cycle while `busy` is low. `busy` stays high until the last byte has been taken downstream. An opcode outside the supported set produces a one-cycle `err` pulse and no bytes.

The sequencer has four named states. IDLE waits for `start`. LOAD_OK (IDLE to EMIT_BODY) is taken on a supported opcode. LOAD_BAD (IDLE to FAULT) is taken on an unsupported one. In EMIT_BODY each accepted byte advances the index. On the last body byte, BODY_TO_CRC goes to EMIT_CRC when the checksum is enabled, and BODY_DONE goes back to IDLE otherwise. CRC_DONE (EMIT_CRC to IDLE) is taken when the checksum byte is accepted. FAULT_DONE (FAULT to IDLE) is taken unconditionally after one cycle.

Top module: `cmd_frame_builder`

## Requirements
- R1: After reset, `busy`, `err` and `byte_valid` are low.
- R2: Single read (0xCA) emits the opcode and then address bytes [23:16], [15:8], [7:0]. Single write (0xC9) emits the same and then the word as bytes [31:24], [23:16], [15:8], [7:0].
- R3: Internal read (0xC4) emits the opcode, address [15:8], address [7:0], then 0x00. Internal write (0xC3) emits the opcode, address [15:8], address [7:0], then the four word bytes high first. For both opcodes, when `clockless` is 1, bit 7 of the first address byte is sent as 1.
- R4: DMA write/read (0xC1/0xC2) emit the opcode, three address bytes high first, then word [15:8] and word [7:0]. Extended DMA write/read (0xC7/0xC8) emit the opcode, three address bytes, then word [23:16], [15:8], [7:0].
- R5: Terminate (0xC5) and repeat (0xC6) emit the opcode followed by three 0x00 bytes. Reset (0xCF) emits the opcode followed by three 0xFF bytes. The address input has no effect on these opcodes.
- R6: With `crc_en` set, one extra byte follows the body. It holds CRC7 (polynomial x^7+x^3+1, register preset to all ones, i.e. 0xFE in byte form) over every body byte including the opcode, bits processed MSB first. The 7-bit result sits in bits 7:1 and bit 0 is 0.
- R7: A start with any other opcode raises `err` for exactly one cycle, with `busy` high for that cycle only, and emits no byte.
- R8: While `byte_valid` is high and `byte_ready` is low, `byte_data` and `byte_valid` hold. Bytes are issued on consecutive cycles when `byte_ready` stays high.
- R9: `busy` rises the cycle after an accepted start and falls right after the final byte is accepted. With `byte_ready` held high, it is high for exactly as many cycles as there are frame bytes. `start` is ignored while `busy` is high.
- R10: `clockless` has no effect on opcodes other than 0xC3 and 0xC4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request strobe, taken only when `busy` is low |
| opcode | input | 8 | Command code |
| addr | input | 24 | Target address |
| word | input | 32 | Write value or transfer length |
| clockless | input | 1 | Marks an internal access as clockless |
| crc_en | input | 1 | Append a CRC7 byte |
| busy | output | 1 | Frame in progress |
| err | output | 1 | One-cycle unsupported-opcode pulse |
| byte_valid | output | 1 | `byte_data` holds a frame byte |
| byte_data | output | 8 | Current frame byte |
| byte_ready | input | 1 | Downstream takes the byte this cycle |

## Verification
The bench builds the block with its default parameters: an eight-byte body buffer, the all-ones checksum preset and the x^7+x^3+1 polynomial. This makes every opcode layout reachable, including the longest eight-byte single-write body and a nine-byte frame with the checksum. A vector table covers every supported opcode, with and without the checksum, with the clockless flag on internal and non-internal accesses, and under both steady and stalling ready patterns. Directed runs then cover reset, unsupported opcodes and a start raised in the middle of a frame.

// File: rtl/cmdfrm_pkg.sv
package cmdfrm_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned ADDR_W = 24;
    localparam int unsigned WORD_W = 32;

    localparam logic [7:0] OPC_DMA_WR     = 8'hC1;
    localparam logic [7:0] OPC_DMA_RD     = 8'hC2;
    localparam logic [7:0] OPC_INT_WR     = 8'hC3;
    localparam logic [7:0] OPC_INT_RD     = 8'hC4;
    localparam logic [7:0] OPC_TERMINATE  = 8'hC5;
    localparam logic [7:0] OPC_REPEAT     = 8'hC6;
    localparam logic [7:0] OPC_XDMA_WR    = 8'hC7;
    localparam logic [7:0] OPC_XDMA_RD    = 8'hC8;
    localparam logic [7:0] OPC_SINGLE_WR  = 8'hC9;
    localparam logic [7:0] OPC_SINGLE_RD  = 8'hCA;
    localparam logic [7:0] OPC_RESET      = 8'hCF;

    localparam logic [7:0] CLOCKLESS_MARK = 8'h80;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_EMIT_BODY = 2'd1,
        ST_EMIT_CRC  = 2'd2,
        ST_FAULT     = 2'd3
    } seq_state_e;

endpackage

// File: rtl/cmdfrm_layout.sv
module cmdfrm_layout
    import cmdfrm_pkg::*;
#(
    parameter int unsigned MAX_BYTES = 8,
    localparam int unsigned LEN_W = $clog2(MAX_BYTES + 1)
) (
    input  logic [7:0]        opcode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] word,
    input  logic              clockless,
    output logic [7:0]        frame_bytes [MAX_BYTES],
    output logic [LEN_W-1:0]  frame_len,
    output logic              supported
);

    logic [7:0] a_hi, a_mid, a_lo;
    logic [7:0] w3, w2, w1, w0;
    logic [7:0] int_hi;

    assign a_hi   = addr[23:16];
    assign a_mid  = addr[15:8];
    assign a_lo   = addr[7:0];
    assign w3     = word[31:24];
    assign w2     = word[23:16];
    assign w1     = word[15:8];
    assign w0     = word[7:0];
    assign int_hi = clockless ? (a_mid | CLOCKLESS_MARK) : a_mid;

    always_comb begin
        for (int i = 0; i < int'(MAX_BYTES); i++) begin
            frame_bytes[i] = 8'h00;
        end
        frame_bytes[0] = opcode;
        frame_len      = LEN_W'(4);
        supported      = 1'b1;
        unique case (opcode)
            OPC_SINGLE_RD: begin
                frame_bytes[1] = a_hi;
                frame_bytes[2] = a_mid;
                frame_bytes[3] = a_lo;
            end
            OPC_SINGLE_WR: begin
                frame_bytes[1] = a_hi;
                frame_bytes[2] = a_mid;
                frame_bytes[3] = a_lo;
                frame_bytes[4] = w3;
                frame_bytes[5] = w2;
                frame_bytes[6] = w1;
                frame_bytes[7] = w0;
                frame_len      = LEN_W'(8);
            end
            OPC_INT_RD: begin
                frame_bytes[1] = int_hi;
                frame_bytes[2] = a_lo;
                frame_bytes[3] = 8'h00;
            end
            OPC_INT_WR: begin
                frame_bytes[1] = int_hi;
                frame_bytes[2] = a_lo;
                frame_bytes[3] = w3;
                frame_bytes[4] = w2;
                frame_bytes[5] = w1;
                frame_bytes[6] = w0;
                frame_len      = LEN_W'(7);
            end
            OPC_DMA_WR, OPC_DMA_RD: begin
                frame_bytes[1] = a_hi;
                frame_bytes[2] = a_mid;
                frame_bytes[3] = a_lo;
                frame_bytes[4] = w1;
                frame_bytes[5] = w0;
                frame_len      = LEN_W'(6);
            end
            OPC_XDMA_WR, OPC_XDMA_RD: begin
                frame_bytes[1] = a_hi;
                frame_bytes[2] = a_mid;
                frame_bytes[3] = a_lo;
                frame_bytes[4] = w2;
                frame_bytes[5] = w1;
                frame_bytes[6] = w0;
                frame_len      = LEN_W'(7);
            end
            OPC_TERMINATE, OPC_REPEAT: begin
                frame_bytes[1] = 8'h00;
                frame_bytes[2] = 8'h00;
                frame_bytes[3] = 8'h00;
            end
            OPC_RESET: begin
                frame_bytes[1] = 8'hFF;
                frame_bytes[2] = 8'hFF;
                frame_bytes[3] = 8'hFF;
            end
            default: begin
                supported = 1'b0;
                frame_len = '0;
            end
        endcase
    end

endmodule

// File: rtl/cmdfrm_crc7.sv
module cmdfrm_crc7 #(
    parameter logic [7:0] POLY_SHIFTED = 8'h12,
    parameter logic [7:0] PRESET       = 8'hFE
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       step,
    input  logic [7:0] data_in,
    output logic [7:0] crc_byte
);

    logic [7:0] crc_q;
    logic [7:0] chain [9];

    assign chain[0] = crc_q;

    for (genvar b = 0; b < 8; b++) begin : g_bit
        logic fb;
        assign fb           = chain[b][7] ^ data_in[7-b];
        assign chain[b + 1] = {chain[b][6:0], 1'b0} ^ (fb ? POLY_SHIFTED : 8'h00);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= PRESET;
        end else if (clear) begin
            crc_q <= PRESET;
        end else if (step) begin
            crc_q <= chain[8];
        end
    end

    assign crc_byte = {crc_q[7:1], 1'b0};

endmodule

// File: rtl/cmd_frame_builder.sv
module cmd_frame_builder
    import cmdfrm_pkg::*;
#(
    parameter int unsigned MAX_BYTES    = 8,
    parameter logic [7:0]  CRC_POLY_SH  = 8'h12,
    parameter logic [7:0]  CRC_PRESET   = 8'hFE,
    localparam int unsigned LEN_W = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] word,
    input  logic              clockless,
    input  logic              crc_en,
    output logic              busy,
    output logic              err,
    output logic              byte_valid,
    output logic [7:0]        byte_data,
    input  logic              byte_ready
);

    seq_state_e state_q, state_d;

    logic [7:0]       lay_bytes [MAX_BYTES];
    logic [LEN_W-1:0] lay_len;
    logic             lay_ok;

    logic [7:0]       frame_q [MAX_BYTES];
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] idx_q;
    logic             crc_en_q;
    logic [7:0]       crc_byte;
    logic             accept;
    logic             take;
    logic             body_step;
    logic             last_body;

    cmdfrm_layout #(.MAX_BYTES(MAX_BYTES)) u_layout (
        .opcode      (opcode),
        .addr        (addr),
        .word        (word),
        .clockless   (clockless),
        .frame_bytes (lay_bytes),
        .frame_len   (lay_len),
        .supported   (lay_ok)
    );

    assign accept    = (state_q == ST_IDLE) && start;
    assign take      = byte_valid && byte_ready;
    assign body_step = (state_q == ST_EMIT_BODY) && take;
    assign last_body = (idx_q == len_q - LEN_W'(1));

    cmdfrm_crc7 #(.POLY_SHIFTED(CRC_POLY_SH), .PRESET(CRC_PRESET)) u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .step     (body_step),
        .data_in  (byte_data),
        .crc_byte (crc_byte)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = lay_ok ? ST_EMIT_BODY : ST_FAULT;
                end
            end
            ST_EMIT_BODY: begin
                if (byte_ready && last_body) begin
                    state_d = crc_en_q ? ST_EMIT_CRC : ST_IDLE;
                end
            end
            ST_EMIT_CRC: begin
                if (byte_ready) begin
                    state_d = ST_IDLE;
                end
            end
            ST_FAULT: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // frame capture and byte index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(MAX_BYTES); i++) begin
                frame_q[i] <= 8'h00;
            end
            len_q    <= '0;
            idx_q    <= '0;
            crc_en_q <= 1'b0;
        end else if (accept) begin
            for (int i = 0; i < int'(MAX_BYTES); i++) begin
                frame_q[i] <= lay_bytes[i];
            end
            len_q    <= lay_len;
            idx_q    <= '0;
            crc_en_q <= crc_en;
        end else if (body_step) begin
            idx_q <= idx_q + LEN_W'(1);
        end
    end

    // outputs per state
    always_comb begin
        busy       = 1'b1;
        err        = 1'b0;
        byte_valid = 1'b0;
        byte_data  = 8'h00;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
            end
            ST_EMIT_BODY: begin
                byte_valid = 1'b1;
                byte_data  = frame_q[idx_q[$clog2(MAX_BYTES)-1:0]];
            end
            ST_EMIT_CRC: begin
                byte_valid = 1'b1;
                byte_data  = crc_byte;
            end
            ST_FAULT: begin
                err = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cmdfrm_checker.sv
module cmdfrm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       err,
    input logic       byte_valid,
    input logic [7:0] byte_data,
    input logic       byte_ready
);

    assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_data)))
        else $error("byte changed while stalled");

    assert_err_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (!err && !busy))
        else $error("err longer than one cycle");

    assert_err_no_bytes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !byte_valid)
        else $error("byte during fault");

    assert_valid_inside_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> busy)
        else $error("byte outside busy");

    assert_busy_falls_after_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(byte_valid && byte_ready) || $past(err)))
        else $error("busy fell without final byte");

endmodule

bind cmd_frame_builder cmdfrm_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .err        (err),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .byte_ready (byte_ready)
);

// File: tb/sim_cmd_frame_builder.sv
module sim_cmd_frame_builder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [23:0] addr = '0;
    logic [31:0] word = '0;
    logic        clockless = 1'b0;
    logic        crc_en = 1'b0;
    logic        busy, err, byte_valid;
    logic [7:0]  byte_data;
    logic        byte_ready = 1'b0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cmd_frame_builder u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .addr(addr),
        .word(word), .clockless(clockless), .crc_en(crc_en), .busy(busy),
        .err(err), .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_ready(byte_ready)
    );

    typedef struct packed {
        logic [7:0]  op;
        logic [23:0] ad;
        logic [31:0] wd;
        logic        ck;
        logic        crc;
        logic [3:0]  n;
        logic [63:0] body;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{8'hCA, 24'h123456, 32'h0,        1'b0, 1'b0, 4'd4, 64'hCA123456_00000000},
        '{8'hC9, 24'hABCDEF, 32'h11223344, 1'b0, 1'b0, 4'd8, 64'hC9ABCDEF_11223344},
        '{8'hC4, 24'h775A3C, 32'h0,        1'b0, 1'b0, 4'd4, 64'hC45A3C00_00000000},
        '{8'hC4, 24'h005A3C, 32'h0,        1'b1, 1'b0, 4'd4, 64'hC4DA3C00_00000000},
        '{8'hC3, 24'h001234, 32'hDEADBEEF, 1'b1, 1'b0, 4'd7, 64'hC39234DE_ADBEEF00},
        '{8'hC1, 24'h010203, 32'h00000456, 1'b0, 1'b0, 4'd6, 64'hC1010203_04560000},
        '{8'hC8, 24'h0A0B0C, 32'h00123456, 1'b0, 1'b0, 4'd7, 64'hC80A0B0C_12345600},
        '{8'hC5, 24'h777777, 32'h0,        1'b0, 1'b0, 4'd4, 64'hC5000000_00000000},
        '{8'hC6, 24'h123456, 32'h0,        1'b0, 1'b0, 4'd4, 64'hC6000000_00000000},
        '{8'hCF, 24'h000000, 32'h0,        1'b0, 1'b0, 4'd4, 64'hCFFFFFFF_00000000},
        '{8'hCA, 24'h123456, 32'h0,        1'b0, 1'b1, 4'd4, 64'hCA123456_00000000},
        '{8'hC9, 24'hABCDEF, 32'h11223344, 1'b1, 1'b1, 4'd8, 64'hC9ABCDEF_11223344},
        '{8'hC7, 24'hFEDCBA, 32'hAA987654, 1'b0, 1'b1, 4'd7, 64'hC7FEDCBA_98765400},
        '{8'hC2, 24'h00FF00, 32'hFFFF8001, 1'b1, 1'b1, 4'd6, 64'hC200FF00_80010000}
    };

    function automatic string tag_of(input logic [7:0] op, input logic ck);
        if (ck && !(op == 8'hC3 || op == 8'hC4)) return "R10";
        case (op)
            8'hC9, 8'hCA: return "R2";
            8'hC3, 8'hC4: return "R3";
            8'hC1, 8'hC2, 8'hC7, 8'hC8: return "R4";
            default: return "R5";
        endcase
    endfunction

    // CRC7, x^7+x^3+1, register in bits 7:1, preset all ones
    function automatic logic [7:0] crc_over(input logic [63:0] body, input int n);
        logic [6:0] r = 7'h7F;
        for (int k = 0; k < n; k++) begin
            for (int b = 7; b >= 0; b--) begin
                logic top = r[6] ^ body[63 - 8*k - (7 - b)];
                r = {r[5:0], 1'b0};
                if (top) r = r ^ 7'h09;
            end
        end
        return {r, 1'b0};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    logic [7:0] got [16];
    int         ngot;
    int         busy_cycles;

    task automatic run_frame(input vec_t v, input bit stall, input bit poke);
        @(negedge clk);
        opcode = v.op; addr = v.ad; word = v.wd; clockless = v.ck; crc_en = v.crc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ngot = 0; busy_cycles = 0;
        for (int c = 0; c < 60; c++) begin
            if (!busy) break;
            busy_cycles++;
            byte_ready = stall ? (c % 3 != 1) : 1'b1;
            if (poke && c == 1) begin
                opcode = 8'hCF; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (byte_valid && byte_ready) begin
                got[ngot] = byte_data;
                ngot++;
            end
            @(negedge clk);
        end
        byte_ready = 1'b0;
        start = 1'b0;
    endtask

    task automatic finish_up;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !err && !byte_valid, "R1", "reset outputs",
              {61'd0, busy, err, byte_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            vec_t v = VECS[i];
            bit st = (i % 2 == 1);
            int exp_n = int'(v.n) + (v.crc ? 1 : 0);
            logic [63:0] act = '0;
            string t = tag_of(v.op, v.ck);
            run_frame(v, st, 1'b0);
            check(ngot == exp_n, t, "byte count", 64'(ngot), 64'(exp_n));
            for (int k = 0; k < 8; k++) begin
                if (k < int'(v.n) && k < ngot) act[63-8*k -: 8] = got[k];
            end
            check(act == v.body, st ? {t, " R8 stalled"} : t, "body bytes", act, v.body);
            if (v.crc) begin
                logic [7:0] ec = crc_over(v.body, int'(v.n));
                logic [7:0] ac = (ngot > int'(v.n)) ? got[v.n] : 8'hxx;
                check(ac === ec, "R6", "crc byte", 64'(ac), 64'(ec));
            end
            if (!st) begin
                check(busy_cycles == exp_n, "R9", "busy cycles back to back",
                      64'(busy_cycles), 64'(exp_n));
            end
        end

        // R7: unsupported opcodes
        for (int j = 0; j < 2; j++) begin
            @(negedge clk);
            opcode = (j == 0) ? 8'hC0 : 8'hCB; crc_en = 1'b1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(err && busy && !byte_valid, "R7", "fault cycle",
                  {61'd0, err, busy, byte_valid}, 64'd6);
            @(negedge clk);
            check(!err && !busy && !byte_valid, "R7", "after fault",
                  {61'd0, err, busy, byte_valid}, 64'd0);
        end

        // R9: start while busy is ignored
        run_frame(VECS[1], 1'b0, 1'b1);
        check(ngot == 8 && got[0] == 8'hC9 && got[7] == 8'h44, "R9",
              "frame under mid-frame start", {got[0], got[7], 48'(ngot)},
              {8'hC9, 8'h44, 48'd8});
        @(negedge clk);
        check(!busy && !byte_valid, "R9", "no second frame",
              {62'd0, busy, byte_valid}, 64'd0);

        finish_up();
    end

endmodule